// File: doc/BRIEF.md
# Fan Parameter Staging Register Block

This block holds the limit and tuning bytes that a fan controller works from, and sets when new values reach it. A host reaches the block over a byte-wide register bus with separate write and read strobes. Every host write to a parameter address lands in a staging copy. The controller reads a second, active copy. After reset the active copy holds per-register defaults, and it keeps them whatever the host writes, until the host sets a commit flag in a control register.

Setting the flag copies every staged byte into the active copy on a single clock edge, so the controller never sees a half-updated set. While the flag stays set, each parameter write updates both copies. Clearing the flag freezes the active copy where it is, and later writes go to staging only. Setting the flag again commits the staging copy again. Reads may be issued at any time and return the staged contents. There is no busy or wait state.

Top module: `fan_param_stage`

## Requirements
- R1: After reset, every active byte equals its per-register default, the start flag reads 0 and `bus_rvalid` is low. In this build the default of parameter i is 30h + 5·i, modulo 256.
- R2: While the start flag is 0, a write to a parameter address (5Ch to 6Eh, index = address − 5Ch) changes the staged byte and leaves `active_params` unchanged.
- R3: A write to control address 40h with data bit 0 set, made while the start flag is 0, copies all staged bytes into `active_params`. The copy is visible in the cycle after the write strobe, and the start flag becomes 1.
- R4: While the start flag is 1, a parameter write updates that byte of `active_params` in the cycle after the strobe, as well as the staged byte.
- R5: A write to 40h with bit 0 clear sets the start flag to 0 and leaves `active_params` unchanged. Later parameter writes update staging only.
- R6: A read strobe returns data on `bus_rdata` with `bus_rvalid` high in the next cycle. A parameter address returns its staged byte.
- R7: Reads of unmapped addresses return 00h. Writes to unmapped addresses change no staged byte, active byte or flag.
- R8: Address 40h stores only bit 0 (the start flag). Bits 7:1 of the write data are ignored, and a read returns them as 0.
- R9: The parameter window ends exactly at 5Ch and 6Eh: both are mapped, while 5Bh and 6Fh behave as unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 8 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_re` |
| start_flag | output | 1 | Current state of the commit flag |
| active_params | output | NUM_PARAMS*8 | Active parameter bytes seen by the controller, byte i at bits 8i+7:8i |

## Verification
The staging function is tested with four write patterns: parameter writes before any commit, a set of the flag, writes while the flag is set, and writes after the flag is cleared and set again. These patterns separate the three outcomes a write can have: staging only, a bulk copy, or a live update. Control writes with only the upper bits set, or with every bit set, show whether the flag decode looks at bit 0 alone. Reads at 5Bh, 5Ch, 6Eh and 6Fh detect an off-by-one at either end of the window.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

  localparam int MAX_REGS = 32;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_CTRL  = 2'd1,
    SEL_PARAM = 2'd2
  } sel_e;

  // Default byte of parameter i: 30h plus five per step.
  function automatic logic [7:0] seed_byte(input int i);
    return 8'(8'h30 + 5 * i);
  endfunction

  function automatic logic [MAX_REGS*8-1:0] seed_defaults();
    logic [MAX_REGS*8-1:0] v;
    v = '0;
    for (int i = 0; i < MAX_REGS; i++) v[i*8 +: 8] = seed_byte(i);
    return v;
  endfunction

endpackage

// File: rtl/fsp_decode.sv
module fsp_decode
  import fsp_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int NUM_PARAMS = 19,
  parameter int BASE_ADDR  = 'h5C,
  parameter int CTRL_ADDR  = 'h40,
  localparam int IDX_W     = $clog2(NUM_PARAMS)
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_e              sel,
  output logic [IDX_W-1:0]  idx
);

  localparam int LAST_ADDR = BASE_ADDR + NUM_PARAMS - 1;

  always_comb begin
    sel = SEL_NONE;
    idx = '0;
    if (addr == ADDR_W'(CTRL_ADDR)) begin
      sel = SEL_CTRL;
    end else if (addr >= ADDR_W'(BASE_ADDR) && addr <= ADDR_W'(LAST_ADDR)) begin
      sel = SEL_PARAM;
      idx = IDX_W'(addr - ADDR_W'(BASE_ADDR));
    end
  end

endmodule

// File: rtl/fsp_slot.sv
module fsp_slot #(
  parameter logic [7:0] DEFAULT_VAL = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stage_we,
  input  logic       live_we,
  input  logic       commit,
  input  logic [7:0] wdata,
  output logic [7:0] staged,
  output logic [7:0] active
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      staged <= DEFAULT_VAL;
      active <= DEFAULT_VAL;
    end else begin
      if (stage_we) staged <= wdata;
      if (commit) active <= staged;
      else if (live_we) active <= wdata;
    end
  end

endmodule

// File: rtl/fsp_readmux.sv
module fsp_readmux
  import fsp_pkg::*;
#(
  parameter int NUM_PARAMS = 19,
  localparam int IDX_W     = $clog2(NUM_PARAMS)
) (
  input  sel_e                      sel,
  input  logic [IDX_W-1:0]          idx,
  input  logic [NUM_PARAMS*8-1:0]   staged_flat,
  input  logic                      start_q,
  output logic [7:0]                data
);

  always_comb begin
    unique case (sel)
      SEL_CTRL:  data = {7'b0, start_q};
      SEL_PARAM: data = staged_flat[idx*8 +: 8];
      default:   data = 8'h00;
    endcase
  end

endmodule

// File: rtl/fan_param_stage.sv
module fan_param_stage
  import fsp_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int NUM_PARAMS = 19,
  parameter int BASE_ADDR  = 'h5C,
  parameter int CTRL_ADDR  = 'h40,
  parameter logic [MAX_REGS*8-1:0] DEFAULTS = seed_defaults()
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [7:0]              bus_wdata,
  input  logic                    bus_we,
  input  logic                    bus_re,
  output logic [7:0]              bus_rdata,
  output logic                    bus_rvalid,
  output logic                    start_flag,
  output logic [NUM_PARAMS*8-1:0] active_params
);

  localparam int IDX_W = $clog2(NUM_PARAMS);

  sel_e             sel;
  logic [IDX_W-1:0] idx;
  logic             start_q;
  logic [NUM_PARAMS*8-1:0] staged_flat;
  logic [7:0]       rd_next;

  // Named events, also used by the bound checker
  logic ctrl_wr_evt;
  logic param_wr_evt;
  logic commit_evt;
  logic live_wr_evt;

  fsp_decode #(
    .ADDR_W(ADDR_W), .NUM_PARAMS(NUM_PARAMS),
    .BASE_ADDR(BASE_ADDR), .CTRL_ADDR(CTRL_ADDR)
  ) u_decode (
    .addr(bus_addr), .sel(sel), .idx(idx)
  );

  assign ctrl_wr_evt  = bus_we && (sel == SEL_CTRL);
  assign param_wr_evt = bus_we && (sel == SEL_PARAM);
  assign commit_evt   = ctrl_wr_evt && bus_wdata[0] && !start_q;
  assign live_wr_evt  = param_wr_evt && start_q;

  always_ff @(posedge clk) begin
    if (!rst_n) start_q <= 1'b0;
    else if (ctrl_wr_evt) start_q <= bus_wdata[0];
  end

  for (genvar g = 0; g < NUM_PARAMS; g++) begin : g_slot
    logic hit;
    assign hit = (idx == IDX_W'(g));
    fsp_slot #(.DEFAULT_VAL(DEFAULTS[g*8 +: 8])) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .stage_we (param_wr_evt && hit),
      .live_we  (live_wr_evt && hit),
      .commit   (commit_evt),
      .wdata    (bus_wdata),
      .staged   (staged_flat[g*8 +: 8]),
      .active   (active_params[g*8 +: 8])
    );
  end

  fsp_readmux #(.NUM_PARAMS(NUM_PARAMS)) u_rmux (
    .sel(sel), .idx(idx), .staged_flat(staged_flat),
    .start_q(start_q), .data(rd_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= 8'h00;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_re;
      if (bus_re) bus_rdata <= rd_next;
    end
  end

  assign start_flag = start_q;

endmodule

// File: rtl/fan_param_stage_chk.sv
module fan_param_stage_chk #(
  parameter int NUM_PARAMS = 19
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    bus_re,
  input logic                    bus_rvalid,
  input logic                    start_flag,
  input logic                    commit_evt,
  input logic [NUM_PARAMS*8-1:0] staged_flat,
  input logic [NUM_PARAMS*8-1:0] active_params
);

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !start_flag |=> (start_flag || $stable(active_params))); // R2

  AST_COMMIT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> (start_flag && active_params == $past(staged_flat))); // R3

  AST_CLEAR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(start_flag) |-> $stable(active_params)); // R5

  AST_RVALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re |=> bus_rvalid); // R6

  AST_RVALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> !bus_rvalid); // R6

endmodule

bind fan_param_stage fan_param_stage_chk #(.NUM_PARAMS(NUM_PARAMS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_re(bus_re), .bus_rvalid(bus_rvalid),
  .start_flag(start_flag), .commit_evt(commit_evt),
  .staged_flat(staged_flat), .active_params(active_params)
);

// File: tb/fan_param_stage_bench.sv
`timescale 1ns/1ps
module fan_param_stage_bench;

  localparam int N = 19;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic [7:0]   bus_wdata = '0;
  logic         bus_we = 1'b0;
  logic         bus_re = 1'b0;
  logic [7:0]   bus_rdata;
  logic         bus_rvalid;
  logic         start_flag;
  logic [N*8-1:0] active_params;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [7:0] m_stage [N];
  logic [7:0] m_active [N];
  logic       m_go;

  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #2.5 clk = ~clk;

  fan_param_stage u_fan_param_stage (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .start_flag(start_flag),
    .active_params(active_params)
  );

  function automatic logic [7:0] dflt(int i);
    logic [7:0] b;
    b = 8'h30;
    for (int k = 0; k < i; k++) b = b + 8'd5;
    return b;
  endfunction

  task automatic check(string tag, logic [N*8-1:0] act, logic [N*8-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_active(string tag);
    logic [N*8-1:0] e;
    for (int i = 0; i < N; i++) e[i*8 +: 8] = m_active[i];
    check(tag, active_params, e);
    check({tag, " start"}, {{(N*8-1){1'b0}}, start_flag}, {{(N*8-1){1'b0}}, m_go});
  endtask

  task automatic do_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    if (a == 8'h40) begin
      if (d[0] && !m_go) for (int i = 0; i < N; i++) m_active[i] = m_stage[i];
      m_go = d[0];
    end else if (a >= 8'h5C && a <= 8'h6E) begin
      m_stage[a - 8'h5C] = d;
      if (m_go) m_active[a - 8'h5C] = d;
    end
  endtask

  function automatic logic [7:0] model_read(logic [7:0] a);
    if (a == 8'h40) return {7'b0, m_go};
    if (a >= 8'h5C && a <= 8'h6E) return m_stage[a - 8'h5C];
    return 8'h00;
  endfunction

  task automatic do_read(logic [7:0] a, string tag);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    exp_q.push_back(model_read(a));
    tag_q.push_back(tag);
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  // Monitor: pops the scoreboard as read data appears
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      tests++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R6: unexpected rvalid got %h expected none", bus_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          fails++;
          $display("FAIL %s: got %h expected %h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #250000;
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_stage[i] = dflt(i);
      m_active[i] = dflt(i);
    end
    m_go = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_active("R1");
    check("R1 rvalid", {{(N*8-1){1'b0}}, bus_rvalid}, '0);
    for (int i = 0; i < N; i++) do_read(8'(8'h5C + i), "R1 R6 default");
    do_read(8'h40, "R8 ctrl reset");

    // R2 writes before commit: staged only
    do_write(8'h5C, 8'h11);
    do_write(8'h64, 8'h77);
    do_write(8'h6E, 8'hEE);
    check_active("R2");
    do_read(8'h5C, "R9 low edge");
    do_read(8'h6E, "R9 high edge");
    do_read(8'h64, "R6 mid");

    // R7/R9 unmapped neighbours
    do_write(8'h5B, 8'hAA);
    do_write(8'h6F, 8'hBB);
    do_write(8'h00, 8'hCC);
    check_active("R7 unmapped write");
    do_read(8'h5B, "R9 below window");
    do_read(8'h6F, "R9 above window");
    do_read(8'hFF, "R7 unmapped");
    do_read(8'h5D, "R7 neighbour intact");

    // R8 upper control bits ignored
    do_write(8'h40, 8'hFE);
    check_active("R8 no commit");
    do_read(8'h40, "R8 ctrl upper");

    // R3 commit
    do_write(8'h40, 8'h01);
    check_active("R3 commit");
    do_read(8'h40, "R3 flag");

    // R4 live writes
    do_write(8'h60, 8'h42);
    check_active("R4 live");
    do_write(8'h6E, 8'h05);
    check_active("R4 live edge");

    // R5 clear holds active
    do_write(8'h40, 8'h00);
    check_active("R5 clear");
    do_write(8'h61, 8'h99);
    check_active("R5 staged only");
    do_read(8'h61, "R5 readback");

    // R3 recommit, R8 all bits set
    do_write(8'h40, 8'hFF);
    check_active("R3 recommit");
    do_read(8'h40, "R8 ctrl all ones");

    repeat (4) @(negedge clk);
    tests++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R6: got %0d pending reads expected 0", exp_q.size());
    end
    finish_run();
  end

endmodule